// File: doc/BRIEF.md
# Single-Operand Read-Modify-Write ALU

This block is the execution stage for the single-operand instructions of an 8-bit CPU. Each instruction reads one operand, changes it and writes it back. The low nibble of the opcode picks the operation. A width select chooses between the byte form and the double-width word form. The block returns the new operand value and the new condition flags. It also returns one write enable per flag and a result write enable, so the register file keeps the old value of every flag that an operation leaves alone.

The operations are:
- negate, ones' complement and clear;
- logical and arithmetic right shift, and left shift;
- rotate left or right through the carry;
- increment and decrement;
- test, which sets flags from the operand and writes nothing back;
- half swap, which rotates the operand by half its width.

The four codes that this opcode space gives to exchange and multiply instructions are not executed here. The block flags them as not handled, and the surrounding core sends them elsewhere. Operand fetch and write-back sit outside the block.

The block has one pipeline stage. A request on a clock edge with `in_valid` high appears at the registered outputs after that edge, together with `out_valid`.

Top module: `una_rmw_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared: `out_valid`, `result`, `result_we`, `flag_val`, `flag_we` and `not_handled` all read zero after that edge.
- R2: The outputs show the request sampled at the previous edge; `out_valid` copies that edge's `in_valid`. With no request, every enable and `not_handled` are zero. `flag_val` and `flag_we` use bit 0 = C, 1 = Z, 2 = N, 3 = V, 4 = H. A flag whose enable is 0 reads 0 in `flag_val`. In every operation, N is the top bit of the result width and Z is set when the result is zero.
- R3: Code 0x0 gives the two's complement of the operand. C is set when the operand is non-zero. V is set when the operand is the most negative value. H is set when the lower half of the operand is non-zero, which is a borrow out of that half. C, Z, N, V and H are written.
- R4: Code 0x3 gives the bitwise inverse of the operand and writes only N and Z.
- R5: Code 0x4 shifts right and fills the top bit with 0. Code 0x7 shifts right and keeps the top bit. For both, C takes the old bit 0, and C, Z and N are written.
- R6: Code 0x8 shifts left with a 0 into bit 0, and C takes the old top bit. C, Z and N are written.
- R7: Code 0x6 rotates right, putting the incoming carry in the top bit and bit 0 in C. Code 0x9 rotates left, putting the incoming carry in bit 0 and the top bit in C. C, Z and N are written.
- R8: Code 0xC adds one and code 0xA subtracts one. C is never written. V is set when increment starts at the largest positive value or decrement starts at the most negative value. H is the carry or borrow out of the lower half of the operand. Z, N, V and H are written.
- R9: Code 0xD writes no result (`result_we` = 0) and writes only N and Z, both taken from the operand.
- R10: Code 0xE exchanges the upper and lower halves of the operand (nibbles in byte form, bytes in word form) and writes only N and Z.
- R11: Code 0xF gives zero, with N = 0 and Z = 1, and writes only N and Z.
- R12: Codes 0x1, 0x2, 0x5 and 0xB raise `not_handled`, with `result_we` = 0 and every flag enable 0.
- R13: With `word_mode` = 0, only the low byte of `operand` is used and the upper byte of `result` is zero. N comes from bit 7 and H from the bit 3 to 4 boundary. With `word_mode` = 1, N comes from bit 15 and H from the bit 7 to 8 boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Opcode low nibble selecting the operation |
| word_mode | input | 1 | 1 = double-width form, 0 = byte form |
| operand | input | 2*DATA_W | Operand value (low byte only in byte form) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs carry a result |
| result | output | 2*DATA_W | New operand value |
| result_we | output | 1 | Result must be written back |
| flag_val | output | 5 | New flag values {H,V,N,Z,C} |
| flag_we | output | 5 | Per-flag write enables {H,V,N,Z,C} |
| not_handled | output | 1 | Code belongs to another unit |

## Verification
The sweeps focus on the values where flag rules change:
- **0x80/0x8000 and 0x7F/0x7FFF.** A wrong overflow rule for negate, increment or decrement would show up at these extremes.
- **Low-half all-ones and all-zeros patterns.** If the half-carry were taken from the nibble boundary in word form, these patterns would give the wrong H.
- **Zero operand for negate.** A design that set C unconditionally would fail here.
- **Both carry-in values for rotates.** A rotate that dropped the incoming carry would fail for one of them.
- **Increment and decrement.** These are watched for a carry enable that leaks through.
- **Test.** This is watched for a result write.
- **The four foreign codes.** These must not produce any enable.
- **Byte form.** The bench checks that the upper operand byte never reaches the result or the flags.

// File: rtl/una_pkg.sv
package una_pkg;

  typedef enum logic [3:0] {
    OP_NEG  = 4'h0,
    OP_FX1  = 4'h1,
    OP_FX2  = 4'h2,
    OP_CPL  = 4'h3,
    OP_SRL  = 4'h4,
    OP_FX5  = 4'h5,
    OP_RRC  = 4'h6,
    OP_SRA  = 4'h7,
    OP_SLL  = 4'h8,
    OP_RLC  = 4'h9,
    OP_DEC  = 4'hA,
    OP_FXB  = 4'hB,
    OP_INC  = 4'hC,
    OP_TNZ  = 4'hD,
    OP_SWAP = 4'hE,
    OP_CLR  = 4'hF
  } una_op_e;

  localparam int FLAG_N_BITS = 5;
  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 3;
  localparam int FB_H = 4;

  typedef struct packed {
    logic                   result_we;
    logic                   unhandled;
    logic [FLAG_N_BITS-1:0] flag_we;
  } una_ctl_t;

endpackage

// File: rtl/una_flag_decode.sv
module una_flag_decode
  import una_pkg::*;
(
  input  una_op_e  op_i,
  output una_ctl_t ctl_o
);

  localparam logic [FLAG_N_BITS-1:0] EN_NZ   = (1 << FB_N) | (1 << FB_Z);
  localparam logic [FLAG_N_BITS-1:0] EN_CNZ  = EN_NZ | (1 << FB_C);
  localparam logic [FLAG_N_BITS-1:0] EN_NZVH = EN_NZ | (1 << FB_V) | (1 << FB_H);
  localparam logic [FLAG_N_BITS-1:0] EN_ALL  = EN_NZVH | (1 << FB_C);

  always_comb begin
    ctl_o.result_we = 1'b1;
    ctl_o.unhandled = 1'b0;
    ctl_o.flag_we   = '0;
    case (op_i)
      OP_NEG:                         ctl_o.flag_we = EN_ALL;
      OP_CPL, OP_SWAP, OP_CLR:        ctl_o.flag_we = EN_NZ;
      OP_SRL, OP_SRA, OP_SLL,
      OP_RRC, OP_RLC:                 ctl_o.flag_we = EN_CNZ;
      OP_INC, OP_DEC:                 ctl_o.flag_we = EN_NZVH;
      OP_TNZ: begin
        ctl_o.flag_we   = EN_NZ;
        ctl_o.result_we = 1'b0;
      end
      default: begin
        ctl_o.result_we = 1'b0;
        ctl_o.unhandled = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/una_lane.sv
module una_lane
  import una_pkg::*;
#(
  parameter int LW = 8
) (
  input  una_op_e       op_i,
  input  logic [LW-1:0] x_i,
  input  logic          cin_i,
  output logic [LW-1:0] res_o,
  output logic          c_o,
  output logic          v_o,
  output logic          h_o
);

  localparam int            HW      = LW / 2;
  localparam logic [LW-1:0] MOST_NEG = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MOST_POS = ~MOST_NEG;
  localparam logic [LW-1:0] ONE      = {{(LW-1){1'b0}}, 1'b1};

  logic [HW-1:0] low_half;
  assign low_half = x_i[HW-1:0];

  always_comb begin
    res_o = x_i;
    c_o   = 1'b0;
    v_o   = 1'b0;
    h_o   = 1'b0;
    case (op_i)
      OP_NEG: begin
        res_o = ~x_i + ONE;
        c_o   = |x_i;
        v_o   = (x_i == MOST_NEG);
        h_o   = |low_half;
      end
      OP_CPL:  res_o = ~x_i;
      OP_SRL: begin
        res_o = {1'b0, x_i[LW-1:1]};
        c_o   = x_i[0];
      end
      OP_SRA: begin
        res_o = {x_i[LW-1], x_i[LW-1:1]};
        c_o   = x_i[0];
      end
      OP_RRC: begin
        res_o = {cin_i, x_i[LW-1:1]};
        c_o   = x_i[0];
      end
      OP_SLL: begin
        res_o = {x_i[LW-2:0], 1'b0};
        c_o   = x_i[LW-1];
      end
      OP_RLC: begin
        res_o = {x_i[LW-2:0], cin_i};
        c_o   = x_i[LW-1];
      end
      OP_INC: begin
        res_o = x_i + ONE;
        v_o   = (x_i == MOST_POS);
        h_o   = &low_half;
      end
      OP_DEC: begin
        res_o = x_i - ONE;
        v_o   = (x_i == MOST_NEG);
        h_o   = ~|low_half;
      end
      OP_SWAP: res_o = {x_i[HW-1:0], x_i[LW-1:HW]};
      OP_CLR:  res_o = '0;
      default: res_o = x_i;
    endcase
  end

endmodule

// File: rtl/una_rmw_alu.sv
module una_rmw_alu
  import una_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [3:0]             op_code,
  input  logic                   word_mode,
  input  logic [2*DATA_W-1:0]    operand,
  input  logic                   carry_in,
  output logic                   out_valid,
  output logic [2*DATA_W-1:0]    result,
  output logic                   result_we,
  output logic [4:0]             flag_val,
  output logic [4:0]             flag_we,
  output logic                   not_handled
);

  localparam int WORD_W  = 2 * DATA_W;
  localparam int N_LANES = 2;

  una_op_e  op;
  una_ctl_t ctl;
  assign op = una_op_e'(op_code);

  una_flag_decode u_dec (
    .op_i  (op),
    .ctl_o (ctl)
  );

  logic [WORD_W-1:0] lane_res [N_LANES];
  logic              lane_c   [N_LANES];
  logic              lane_v   [N_LANES];
  logic              lane_h   [N_LANES];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = DATA_W << g;
    logic [LW-1:0] r;
    una_lane #(.LW(LW)) u_lane (
      .op_i  (op),
      .x_i   (operand[LW-1:0]),
      .cin_i (carry_in),
      .res_o (r),
      .c_o   (lane_c[g]),
      .v_o   (lane_v[g]),
      .h_o   (lane_h[g])
    );
    assign lane_res[g] = WORD_W'(r);
  end

  logic [WORD_W-1:0] sel_res;
  logic [4:0]        raw_flags;
  logic              sel_n;

  always_comb begin
    sel_res = word_mode ? lane_res[1] : lane_res[0];
    sel_n   = word_mode ? sel_res[WORD_W-1] : sel_res[DATA_W-1];
    raw_flags        = '0;
    raw_flags[FB_C]  = word_mode ? lane_c[1] : lane_c[0];
    raw_flags[FB_Z]  = (sel_res == '0);
    raw_flags[FB_N]  = sel_n;
    raw_flags[FB_V]  = word_mode ? lane_v[1] : lane_v[0];
    raw_flags[FB_H]  = word_mode ? lane_h[1] : lane_h[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      result_we   <= 1'b0;
      flag_val    <= '0;
      flag_we     <= '0;
      not_handled <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      result      <= in_valid ? sel_res : '0;
      result_we   <= in_valid & ctl.result_we;
      flag_we     <= in_valid ? ctl.flag_we : '0;
      flag_val    <= in_valid ? (raw_flags & ctl.flag_we) : '0;
      not_handled <= in_valid & ctl.unhandled;
    end
  end

endmodule

// File: rtl/una_rmw_alu_chk.sv
module una_rmw_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [3:0]          op_code,
  input logic                word_mode,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] result,
  input logic                result_we,
  input logic [4:0]          flag_val,
  input logic [4:0]          flag_we,
  input logic                not_handled
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !result_we && flag_we == 5'd0 && !not_handled));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!result_we && flag_we == 5'd0 && !not_handled));

  // R12
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    not_handled |-> (!result_we && flag_we == 5'd0));

  // R8
  incdec_carry_kept_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && (op_code == 4'hA || op_code == 4'hC)) |-> !flag_we[0]);

  // R9
  test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && op_code == 4'hD) |-> (!result_we && flag_we == 5'b00110));

  // R11
  clear_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && op_code == 4'hF) |-> (result == '0 && flag_val[1] && !flag_val[2]));

  // R13
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !word_mode) |-> (result[2*DATA_W-1:DATA_W] == '0));

endmodule

bind una_rmw_alu una_rmw_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_code     (op_code),
  .word_mode   (word_mode),
  .out_valid   (out_valid),
  .result      (result),
  .result_we   (result_we),
  .flag_val    (flag_val),
  .flag_we     (flag_we),
  .not_handled (not_handled)
);

// File: tb/tb_una_rmw_alu.sv
module tb_una_rmw_alu;

  localparam int DATA_W = 8;
  localparam int WW     = 2 * DATA_W;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [3:0]    op_code;
  logic          word_mode;
  logic [WW-1:0] operand;
  logic          carry_in;
  logic          out_valid;
  logic [WW-1:0] result;
  logic          result_we;
  logic [4:0]    flag_val;
  logic [4:0]    flag_we;
  logic          not_handled;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  una_rmw_alu #(.DATA_W(DATA_W)) dut (
    .clk, .rst, .in_valid, .op_code, .word_mode, .operand, .carry_in,
    .out_valid, .result, .result_we, .flag_val, .flag_we, .not_handled
  );

  function automatic string tag_of(input int code, input bit w);
    string t;
    case (code)
      0:       t = "R3";
      3:       t = "R4";
      4, 7:    t = "R5";
      8:       t = "R6";
      6, 9:    t = "R7";
      10, 12:  t = "R8";
      13:      t = "R9";
      14:      t = "R10";
      15:      t = "R11";
      default: t = "R12";
    endcase
    if (w) t = {t, "/R13"};
    return t;
  endfunction

  task automatic model(input int code, input bit w, input int opd, input bit ci,
                       output int r, output bit rwe, output bit [4:0] fv,
                       output bit [4:0] fwe, output bit un);
    int width = w ? 16 : 8;
    int mask  = (1 << width) - 1;
    int hmask = (1 << (width / 2)) - 1;
    int top   = 1 << (width - 1);
    int x     = opd & mask;
    bit c = 0, v = 0, h = 0;
    r = x; rwe = 1; un = 0; fwe = 5'b00110;
    case (code)
      0:  begin r = (0 - x) & mask; c = (x != 0); v = (x == top);
                h = ((x & hmask) != 0); fwe = 5'b11111; end
      3:  r = (~x) & mask;
      4:  begin r = x >> 1; c = x & 1; fwe = 5'b00111; end
      7:  begin r = (x >> 1) | (x & top); c = x & 1; fwe = 5'b00111; end
      6:  begin r = (x >> 1) | (ci ? top : 0); c = x & 1; fwe = 5'b00111; end
      8:  begin r = (x << 1) & mask; c = (x & top) != 0; fwe = 5'b00111; end
      9:  begin r = ((x << 1) & mask) | ci; c = (x & top) != 0; fwe = 5'b00111; end
      12: begin r = (x + 1) & mask; v = (x == top - 1);
                h = ((x & hmask) == hmask); fwe = 5'b11110; end
      10: begin r = (x + mask) & mask; v = (x == top);
                h = ((x & hmask) == 0); fwe = 5'b11110; end
      13: rwe = 0;
      14: r = ((x << (width / 2)) | (x >> (width / 2))) & mask;
      15: r = 0;
      default: begin rwe = 0; un = 1; fwe = 5'b00000; end
    endcase
    fv = {h, v, ((r & top) != 0), (r == 0), c} & fwe;
  endtask

  task automatic run_one(input int code, input bit w, input int opd, input bit ci);
    int er; bit erwe, eun; bit [4:0] efv, efwe;
    op_code = 4'(code); word_mode = w; operand = WW'(opd); carry_in = ci;
    in_valid = 1'b1;
    model(code, w, opd, ci, er, erwe, efv, efwe, eun);
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (!out_valid || result !== WW'(er) || result_we !== erwe ||
        flag_val !== efv || flag_we !== efwe || not_handled !== eun) begin
      n_fail++;
      $display("FAIL %s op=%h w=%0d x=%h ci=%0d: got v=%0d res=%h we=%0d fl=%b fwe=%b un=%0d exp res=%h we=%0d fl=%b fwe=%b un=%0d",
               tag_of(code, w), code, w, opd, ci, out_valid, result, result_we,
               flag_val, flag_we, not_handled, er[WW-1:0], erwe, efv, efwe, eun);
    end
  endtask

  task automatic check_idle(input string tag);
    in_valid = 1'b0;
    operand  = '1;
    op_code  = 4'h0;
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (out_valid || result_we || flag_we != 0 || not_handled || result != 0) begin
      n_fail++;
      $display("FAIL %s idle: got v=%0d we=%0d fwe=%b un=%0d res=%h exp all zero",
               tag, out_valid, result_we, flag_we, not_handled, result);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_code = 4'h0; word_mode = 1'b0;
    operand = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_tests++;
    if (out_valid || result != 0 || result_we || flag_val != 0 || flag_we != 0 || not_handled) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0d res=%h we=%0d fl=%b fwe=%b un=%0d exp all zero",
               out_valid, result, result_we, flag_val, flag_we, not_handled);
    end
    rst = 1'b0;
    // R2: no request gives no enables
    check_idle("R2");

    // Byte form, exhaustive; upper byte of operand filled with noise (R13)
    for (int code = 0; code < 16; code++)
      for (int x = 0; x < 256; x++)
        for (int ci = 0; ci < 2; ci++)
          run_one(code, 1'b0, ((x * 37 + code) & 8'hFF) << 8 | x, ci[0]);

    check_idle("R2");

    // Word form: corner values then a spread of values (R13)
    for (int code = 0; code < 16; code++) begin
      int corners [10] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'h7FFF,
                           16'h8000, 16'hFFFF, 16'h80FF, 16'h7F00, 16'h1234};
      foreach (corners[k])
        for (int ci = 0; ci < 2; ci++)
          run_one(code, 1'b1, corners[k], ci[0]);
      for (int i = 0; i < 768; i++)
        run_one(code, 1'b1, (i * 40503 + 17) & 16'hFFFF, i[0]);
    end

    check_idle("R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got hang exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule